// File: doc/BRIEF.md
# Sub-array Activation Timing Gate

This block sits beside one bank's command scheduler in a memory controller where the bank is split into several sub-arrays, each with its own row buffer. It watches the command stream that is issued to the bank: activate, read, write and precharge, together with the target sub-array. From these commands it keeps the timing state that decides whether an activate may go out. Every cycle it reports on a single registered output whether an activate to a candidate sub-array would be legal at the next clock edge.

An activate aimed at a sub-array other than the open one may overlap the open page. It needs no precharge and no row-precharge wait. After a read-only page it waits for the row-active time. After a page that took a write it waits for the row-to-column delay, the write latency, four clocks and the write-to-activate margin. Opening a new sub-array closes all others, so at most one page is open per bank. An activate to the open sub-array itself follows the conventional row-active or write-recovery rule, plus row-precharge. Write recovery comes in two programmed lengths, and a periodically sampled temperature flag chooses between them. The longer value applies while the part is cold.

All delays are runtime inputs in clock cycles. Commands are assumed legal; the block gates only activates and enforces nothing itself.

Top module: `subarray_act_gate`

## Requirements
- R1: While `rst` is high `act_ok` is 0; the sub-array state resets to closed with no pending delays, so `act_ok` is 1 in the cycle after the first clock edge with `rst` low.
- R2: A command takes effect at a clock edge where `cmd_valid` is 1, with `cmd_type` encoded 0 = activate, 1 = read, 2 = write, 3 = precharge; with `cmd_valid` at 0 the state is unchanged and `cmd_type` is ignored.
- R3: `act_ok` is registered: after edge e it states whether an activate at edge e+1 to the `cand_sa` value sampled at edge e meets the rules below; a delay of D cycles from a command at edge c permits an activate at edge c+D or later.
- R4: With a page open and no write since its activate, an activate to a different sub-array is allowed from `cfg_tras` cycles after that activate.
- R5: With a page open and at least one write since its activate, an activate to a different sub-array is allowed from `cfg_trcd + cfg_wl + 4 + cfg_twa` cycles after that activate.
- R6: An activate to the sub-array that is already open is allowed only once both `cfg_tras + cfg_trp` cycles have passed since its activate and, for every write since then, the write-recovery value used by that write plus `cfg_trp` cycles have passed since the write.
- R7: After a precharge the bank is closed, and any activate is allowed from `cfg_trp` cycles after the precharge.
- R8: An activate makes its target the only open sub-array; the rules of R4 to R6 then refer to the new page and its own activate time, with the write history cleared.
- R9: A `temp_sample` pulse loads `temp_hot`; write recovery is `cfg_twr_hot` when the loaded flag is 1 and `cfg_twr_cold` when it is 0 (0 after reset); each write uses the selection in force before that edge, so a later sample never alters a delay already started.
- R10: Any delay sum in R4 to R7 that evaluates to 0 acts as 1 cycle; counters hold sums up to 3 × (2^T_W − 1) + 4 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued at this edge |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_sa | input | SA_W | Sub-array index of the command |
| cand_sa | input | SA_W | Sub-array of the candidate activate |
| temp_sample | input | 1 | Poll strobe that loads the temperature flag |
| temp_hot | input | 1 | 1 when above the temperature threshold |
| cfg_tras | input | T_W | Row-active time, cycles |
| cfg_trp | input | T_W | Row-precharge time, cycles |
| cfg_trcd | input | T_W | Row-to-column delay, cycles |
| cfg_wl | input | T_W | Write latency, cycles |
| cfg_twa | input | T_W | Write-to-activate margin, cycles |
| cfg_twr_cold | input | T_W | Write recovery below the threshold |
| cfg_twr_hot | input | T_W | Write recovery above the threshold |
| act_ok | output | 1 | Registered activate-allowed flag for the candidate |

## Verification
A wrong open sub-array or a lost write flag shows up at once. The rule chosen for the candidate changes, so `act_ok` rises or falls on the wrong cycle, and this happens the first time the candidate differs from the tracked page. A counter that loads or decays wrongly shows up as an edge of `act_ok` one or more cycles away from the computed deadline. A stale temperature selection shows up only after a write, when the same-sub-array release moves by the difference between the two recovery values. The stimulus therefore mixes writes, temperature polls and candidate changes so that each of these errors is exposed within a few tens of cycles.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } sag_cmd_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
    } sag_dec_t;

    function automatic sag_dec_t sag_decode(input logic vld, input logic [1:0] kind);
        sag_dec_t d;
        d.act = vld && (kind == CMD_ACT);
        d.rd  = vld && (kind == CMD_RD);
        d.wr  = vld && (kind == CMD_WR);
        d.pre = vld && (kind == CMD_PRE);
        return d;
    endfunction

    // A delay of D cycles loads D-1; a zero delay behaves as one cycle.
    function automatic int unsigned sag_span(input int unsigned d);
        return (d == 0) ? 0 : d - 1;
    endfunction

endpackage

// File: rtl/sag_down_ctr.sv
module sag_down_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         ld_max,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    logic [W-1:0] dec;

    always_comb begin
        dec = (cnt == '0) ? '0 : cnt - W'(1);
        if (ld) begin
            cnt_nxt = (ld_max && (dec > ld_val)) ? dec : ld_val;
        end else begin
            cnt_nxt = dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end
endmodule

// File: rtl/sag_twr_sel.sv
module sag_twr_sel #(
    parameter int T_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sample,
    input  logic           hot_in,
    input  logic [T_W-1:0] twr_cold,
    input  logic [T_W-1:0] twr_hot,
    output logic           hot_q,
    output logic [T_W-1:0] twr_eff
);
    always_ff @(posedge clk) begin
        if (rst)         hot_q <= 1'b0;
        else if (sample) hot_q <= hot_in;
    end

    assign twr_eff = hot_q ? twr_hot : twr_cold;
endmodule

// File: rtl/sag_open_track.sv
module sag_open_track
    import sag_pkg::*;
#(
    parameter int NUM_SA = 2,
    parameter int SA_W   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  sag_dec_t          dec,
    input  logic [SA_W-1:0]   cmd_sa,
    output logic              open_vld,
    output logic [SA_W-1:0]   open_sa,
    output logic              wrote,
    output logic              vld_nxt,
    output logic [SA_W-1:0]   sa_nxt,
    output logic              wrote_nxt,
    output logic [NUM_SA-1:0] open_vec
);
    always_comb begin
        vld_nxt   = open_vld;
        sa_nxt    = open_sa;
        wrote_nxt = wrote;
        if (dec.act) begin
            vld_nxt   = 1'b1;
            sa_nxt    = cmd_sa;
            wrote_nxt = 1'b0;
        end else if (dec.wr) begin
            wrote_nxt = 1'b1;
        end else if (dec.pre) begin
            vld_nxt   = 1'b0;
            wrote_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_vld <= 1'b0;
            open_sa  <= '0;
            wrote    <= 1'b0;
        end else begin
            open_vld <= vld_nxt;
            open_sa  <= sa_nxt;
            wrote    <= wrote_nxt;
        end
    end

    for (genvar i = 0; i < NUM_SA; i++) begin : g_vec
        assign open_vec[i] = open_vld && (open_sa == SA_W'(i));
    end
endmodule

// File: rtl/subarray_act_gate.sv
module subarray_act_gate
    import sag_pkg::*;
#(
    parameter int NUM_SA = 2,
    parameter int T_W    = 8,
    localparam int SA_W  = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_type,
    input  logic [SA_W-1:0] cmd_sa,
    input  logic [SA_W-1:0] cand_sa,
    input  logic            temp_sample,
    input  logic            temp_hot,
    input  logic [T_W-1:0]  cfg_tras,
    input  logic [T_W-1:0]  cfg_trp,
    input  logic [T_W-1:0]  cfg_trcd,
    input  logic [T_W-1:0]  cfg_wl,
    input  logic [T_W-1:0]  cfg_twa,
    input  logic [T_W-1:0]  cfg_twr_cold,
    input  logic [T_W-1:0]  cfg_twr_hot,
    output logic            act_ok
);
    localparam int CNT_W = T_W + 2;

    sag_dec_t          dec;
    logic              open_vld, wrote, vld_nxt, wrote_nxt;
    logic [SA_W-1:0]   open_sa, sa_nxt;
    logic [NUM_SA-1:0] open_vec;
    logic              hot_q;
    logic [T_W-1:0]    twr_eff;

    logic [CNT_W-1:0]  ras_ld, salp_ld, same_act_ld, same_wr_ld, rp_ld, same_ld;
    logic [CNT_W-1:0]  ras_cnt, ras_nxt, salp_cnt, salp_nxt;
    logic [CNT_W-1:0]  same_cnt, same_nxt, rp_cnt, rp_nxt;
    logic              allow_nxt;

    assign dec = sag_decode(cmd_valid, cmd_type);

    always_comb begin
        ras_ld      = CNT_W'(sag_span(32'(cfg_tras)));
        salp_ld     = CNT_W'(sag_span(32'(cfg_trcd) + 32'(cfg_wl) + 32'(cfg_twa) + 32'd4));
        same_act_ld = CNT_W'(sag_span(32'(cfg_tras) + 32'(cfg_trp)));
        same_wr_ld  = CNT_W'(sag_span(32'(twr_eff) + 32'(cfg_trp)));
        rp_ld       = CNT_W'(sag_span(32'(cfg_trp)));
        same_ld     = dec.wr ? same_wr_ld : same_act_ld;
    end

    sag_twr_sel #(.T_W(T_W)) u_twr (
        .clk(clk), .rst(rst), .sample(temp_sample), .hot_in(temp_hot),
        .twr_cold(cfg_twr_cold), .twr_hot(cfg_twr_hot),
        .hot_q(hot_q), .twr_eff(twr_eff)
    );

    sag_open_track #(.NUM_SA(NUM_SA), .SA_W(SA_W)) u_trk (
        .clk(clk), .rst(rst), .dec(dec), .cmd_sa(cmd_sa),
        .open_vld(open_vld), .open_sa(open_sa), .wrote(wrote),
        .vld_nxt(vld_nxt), .sa_nxt(sa_nxt), .wrote_nxt(wrote_nxt),
        .open_vec(open_vec)
    );

    sag_down_ctr #(.W(CNT_W)) u_ras (
        .clk(clk), .rst(rst), .ld(dec.act), .ld_max(1'b0), .ld_val(ras_ld),
        .cnt(ras_cnt), .cnt_nxt(ras_nxt)
    );

    sag_down_ctr #(.W(CNT_W)) u_salp (
        .clk(clk), .rst(rst), .ld(dec.act), .ld_max(1'b0), .ld_val(salp_ld),
        .cnt(salp_cnt), .cnt_nxt(salp_nxt)
    );

    sag_down_ctr #(.W(CNT_W)) u_same (
        .clk(clk), .rst(rst), .ld(dec.act | dec.wr), .ld_max(dec.wr), .ld_val(same_ld),
        .cnt(same_cnt), .cnt_nxt(same_nxt)
    );

    sag_down_ctr #(.W(CNT_W)) u_rp (
        .clk(clk), .rst(rst), .ld(dec.pre), .ld_max(1'b0), .ld_val(rp_ld),
        .cnt(rp_cnt), .cnt_nxt(rp_nxt)
    );

    always_comb begin
        if (!vld_nxt)               allow_nxt = (rp_nxt == '0);
        else if (cand_sa == sa_nxt) allow_nxt = (same_nxt == '0);
        else if (wrote_nxt)         allow_nxt = (salp_nxt == '0);
        else                        allow_nxt = (ras_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) act_ok <= 1'b0;
        else     act_ok <= allow_nxt;
    end
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
    parameter int NUM_SA = 2,
    parameter int SA_W   = 1,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_type,
    input logic [SA_W-1:0]   cmd_sa,
    input logic              temp_sample,
    input logic              temp_hot,
    input logic              act_ok,
    input logic [NUM_SA-1:0] open_vec,
    input logic              open_vld,
    input logic [SA_W-1:0]   open_sa,
    input logic [CNT_W-1:0]  ras_cnt,
    input logic              hot_q
);
    logic is_act, is_pre;
    assign is_act = cmd_valid && (cmd_type == 2'd0);
    assign is_pre = cmd_valid && (cmd_type == 2'd3);

    p_reset_low_r1: assert property (@(posedge clk) rst |=> !act_ok);

    p_one_open_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(open_vec));

    p_act_opens_r8: assert property (@(posedge clk) disable iff (rst)
        is_act |=> (open_vld && open_sa == $past(cmd_sa)));

    p_pre_closes_r7: assert property (@(posedge clk) disable iff (rst)
        is_pre |=> !open_vld);

    p_ras_no_rise_r4: assert property (@(posedge clk) disable iff (rst)
        !is_act |=> (ras_cnt <= $past(ras_cnt)));

    p_temp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !temp_sample |=> (hot_q == $past(hot_q)));

    p_temp_load_r9: assert property (@(posedge clk) disable iff (rst)
        temp_sample |=> (hot_q == $past(temp_hot)));
endmodule

bind subarray_act_gate sag_chk #(.NUM_SA(NUM_SA), .SA_W(SA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_sa(cmd_sa),
    .temp_sample(temp_sample), .temp_hot(temp_hot), .act_ok(act_ok),
    .open_vec(open_vec), .open_vld(open_vld), .open_sa(open_sa),
    .ras_cnt(ras_cnt), .hot_q(hot_q)
);

// File: tb/sim_subarray_act_gate.sv
`timescale 1ns/1ps
module sim_subarray_act_gate;
    localparam int NUM_SA = 2;
    localparam int T_W    = 8;
    localparam int SA_W   = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_type = 2'd0;
    logic [SA_W-1:0] cmd_sa = '0, cand_sa = '0;
    logic temp_sample = 1'b0, temp_hot = 1'b0;
    logic [T_W-1:0] cfg_tras, cfg_trp, cfg_trcd, cfg_wl, cfg_twa, cfg_twr_cold, cfg_twr_hot;
    logic act_ok;

    always #10 clk = ~clk;

    subarray_act_gate #(.NUM_SA(NUM_SA), .T_W(T_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_sa(cmd_sa),
        .cand_sa(cand_sa), .temp_sample(temp_sample), .temp_hot(temp_hot),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_wl(cfg_wl),
        .cfg_twa(cfg_twa), .cfg_twr_cold(cfg_twr_cold), .cfg_twr_hot(cfg_twr_hot),
        .act_ok(act_ok)
    );

    int checks = 0, bad = 0;
    bit done = 1'b0;

    // Reference model, kept as absolute edge numbers.
    int e = 0;
    bit m_open = 1'b0, m_wrote = 1'b0, m_hot = 1'b0;
    int m_sa = 0;
    int pre_due = 0, same_due = 0, rd_due = 0, wr_due = 0;
    string phase = "R3";

    function automatic int at_least1(input int x);
        return (x < 1) ? 1 : x;
    endfunction

    function automatic bit legal(input int f, input int sa);
        if (!m_open)        return f >= pre_due;
        if (sa == m_sa)     return f >= same_due;
        if (m_wrote)        return f >= wr_due;
        return f >= rd_due;
    endfunction

    function automatic string rule_tag(input int sa);
        if (!m_open)    return "R7";
        if (sa == m_sa) return "R6 R9";
        if (m_wrote)    return "R5 R8";
        return "R4 R8";
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: act_ok=%0b expected=%0b edge=%0d", tag, got, exp, e);
        end
    endtask

    // Drive at a falling edge, take the rising edge, update the model, check at the next falling edge (R2 R3).
    task automatic step(input bit v, input int t, input int sa, input int cand,
                        input bit ts, input bit th);
        cmd_valid   = v;
        cmd_type    = 2'(t);
        cmd_sa      = SA_W'(sa);
        cand_sa     = SA_W'(cand);
        temp_sample = ts;
        temp_hot    = th;
        @(posedge clk);
        e++;
        if (v) begin
            case (t)
                0: begin
                    m_open = 1'b1; m_sa = sa; m_wrote = 1'b0;
                    rd_due   = e + at_least1(int'(cfg_tras));
                    wr_due   = e + at_least1(int'(cfg_trcd) + int'(cfg_wl) + 4 + int'(cfg_twa));
                    same_due = e + at_least1(int'(cfg_tras) + int'(cfg_trp));
                end
                2: begin
                    int d;
                    m_wrote = 1'b1;
                    d = e + at_least1((m_hot ? int'(cfg_twr_hot) : int'(cfg_twr_cold)) + int'(cfg_trp));
                    if (d > same_due) same_due = d;
                end
                3: begin
                    m_open = 1'b0; m_wrote = 1'b0;
                    pre_due = e + at_least1(int'(cfg_trp));
                end
                default: ;
            endcase
        end
        if (ts) m_hot = th;
        @(negedge clk);
        check(act_ok, legal(e + 1, cand), {rule_tag(cand), " ", phase});
    endtask

    task automatic set_cfg(input int ras, input int rp, input int rcd, input int wl,
                           input int wa, input int wrc, input int wrh);
        cfg_tras = T_W'(ras); cfg_trp = T_W'(rp); cfg_trcd = T_W'(rcd);
        cfg_wl = T_W'(wl); cfg_twa = T_W'(wa); cfg_twr_cold = T_W'(wrc); cfg_twr_hot = T_W'(wrh);
    endtask

    task automatic run_random(input int n);
        int cand = 0;
        for (int i = 0; i < n; i++) begin
            int r = int'($urandom % 100);
            bit ts = ($urandom % 10) == 0;
            bit th = $urandom % 2;
            if (($urandom % 4) == 0) cand = int'($urandom % NUM_SA);
            if (m_open && r < 15)      step(1, 1, m_sa, cand, ts, th);
            else if (m_open && r < 30) step(1, 2, m_sa, cand, ts, th);
            else if (m_open && r < 37) step(1, 3, m_sa, cand, ts, th);
            else if (r < 60) begin
                int sa = int'($urandom % NUM_SA);
                if (legal(e + 1, sa)) step(1, 0, sa, cand, ts, th);
                else                  step(0, int'($urandom % 4), sa, cand, ts, th); // R2 ignored type
            end else begin
                step(0, int'($urandom % 4), int'($urandom % NUM_SA), cand, ts, th);   // R2 idle
            end
        end
    endtask

    initial begin
        int seed_val;
        seed_val = int'($urandom(32'hC0DE5A1));
        set_cfg(12, 5, 4, 3, 2, 24, 8);
        @(negedge clk);
        @(negedge clk);
        check(act_ok, 1'b0, "R1 in reset");
        @(negedge clk);
        check(act_ok, 1'b0, "R1 in reset");
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0);   // R1: first edge out of reset gives act_ok = 1
        check(act_ok, 1'b1, "R1 after reset");

        // Directed: write on the same edge as a hot sample still uses cold recovery (R9).
        step(1, 0, 0, 0, 0, 0);
        step(1, 2, 0, 0, 1, 1);
        for (int k = 0; k < 45; k++) step(0, 0, 0, (k < 20) ? 1 : 0, 0, 0);
        // Directed: activate the other sub-array once allowed, then it alone is open (R5 R8).
        step(1, 0, 1, 0, 0, 0);
        for (int k = 0; k < 30; k++) step(0, 0, 0, k % 2, 0, 0);
        step(1, 3, 1, 1, 0, 0);
        for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 0, 0);

        run_random(1500);

        phase = "R10";
        step(1, 3, m_sa, 0, 0, 0);
        for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 0, 0);
        set_cfg(0, 0, 0, 0, 0, 0, 3);
        run_random(1200);

        step(1, 3, m_sa, 0, 0, 0);
        for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 0, 0);
        set_cfg(200, 30, 20, 18, 9, 255, 51);
        run_random(2500);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule